// File: doc/BRIEF.md
# Byte-Swapping PCI Host Bridge Address Decoder

This block accepts single 32-bit accesses from a big-endian processor bus and decides where each one goes. Four address windows are turned into requests on a simple valid/ready PCI-side port, each tagged with its space (memory, I/O, boot ROM) and a translated address. Two small windows are served inside the block: the configuration-address register, which picks a bus/device/function/register target, and the configuration-data port, which either reaches the bridge's own header registers or turns into a configuration request on the PCI side.

The processor bus is big-endian and the configuration registers are little-endian. So the bridge reverses the bytes of every configuration-address word in both directions. Configuration-data words are reversed too, together with their byte enables, unless the selected target is the bridge itself (bus 0, device 0, function 0). Those words pass unchanged. Memory, I/O and ROM traffic is never swapped.

Only one access is in flight at a time. Internally served accesses answer one cycle after acceptance. Forwarded accesses answer one cycle after the PCI side returns its response.

Top module: `hb_bridge`

## Requirements
- R1: A CPU address from 0x80000000 to 0xFCFFFFFF is forwarded in memory space (`pci_req_space`=0) with the PCI address equal to the CPU address.
- R2: A CPU address from 0xFD000000 to 0xFDFFFFFF is forwarded in memory space with the PCI address equal to the CPU address minus 0xFD000000.
- R3: A CPU address from 0xFE000000 to 0xFE00FFFF is forwarded in I/O space (`pci_req_space`=1) at address minus 0xFE000000. A CPU address from 0xFE800000 to 0xFEBFFFFF is forwarded in I/O space at address minus 0xFE800000 plus 0x00800000.
- R4: A CPU address at or above 2^32 minus 2^ROM_LOG2 is forwarded in ROM space (`pci_req_space`=3) with the offset inside the ROM as address.
- R5: Writes to 0xFEC00000–0xFEDFFFFF store the data byte-reversed (lane 0↔3, 1↔2, lane i = bits 8i+7:8i, byte enable i covers lane i). Enables are reversed the same way. Reads return the stored value byte-reversed, one cycle after acceptance.
- R6: After reset the stored configuration address is 0xFFFFFFFF. No request or response is pending, and `cfg_bus/dev/func/reg` show the stored address fields (bits 23:16, 15:11, 10:8, 7:2).
- R7: A configuration-data access (0xFEE00000–0xFEEFFFFF) whose stored address bits 31:8 differ from 0x800000 is forwarded in configuration space (`pci_req_space`=2) at the stored address with bits 1:0 cleared. Write data and enables are byte-reversed, and the read data returned is byte-reversed.
- R8: When stored address bits 31:8 equal 0x800000, configuration-data accesses are served internally and unswapped. Register 1 (offset 0x04) reads 0x00800006 (status 0x0080, command 0x0006).
- R9: At offset 0x70 the bridge holds a 16-bit register in lanes 0–1 and an 8-bit register in lane 2, both reset to 0. A write updates only the enabled lanes; lane 3 reads 0.
- R10: Any other address reads 0xFFFFFFFF one cycle after acceptance, with no PCI request. Writes there change nothing.
- R11: While `pci_req_valid` is high and `pci_req_ready` is low, the request and all its fields are held unchanged.
- R12: Memory, I/O and ROM requests carry the CPU write data, write flag and byte enables unchanged, and their read data is returned unchanged.
- R13: Only one access is in flight: `cpu_req_ready` stays low from the acceptance of a forwarded access until its response, and each access gives exactly one one-cycle `cpu_rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU access request |
| cpu_req_ready | output | 1 | Bridge can accept an access |
| cpu_req_we | input | 1 | 1 = write |
| cpu_req_addr | input | 32 | CPU byte address |
| cpu_req_wdata | input | 32 | CPU write data |
| cpu_req_be | input | 4 | CPU byte enables |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | 32 | Read data for the CPU |
| pci_req_valid | output | 1 | PCI-side request valid |
| pci_req_ready | input | 1 | PCI side takes the request |
| pci_req_space | output | 2 | 0 mem, 1 I/O, 2 config, 3 ROM |
| pci_req_we | output | 1 | Request is a write |
| pci_req_addr | output | 32 | Translated address |
| pci_req_wdata | output | 32 | Write data (swapped for config) |
| pci_req_be | output | 4 | Byte enables (reversed for config) |
| pci_rsp_valid | input | 1 | PCI-side response strobe |
| pci_rsp_rdata | input | 32 | PCI-side read data |
| cfg_bus | output | 8 | Selected configuration bus |
| cfg_dev | output | 5 | Selected configuration device |
| cfg_func | output | 3 | Selected configuration function |
| cfg_reg | output | 6 | Selected configuration dword register |

## Verification
A wrong stored configuration address shows at the next read of the address port, byte-reversed. It also shows in `cfg_bus/dev/func/reg` in the same cycle, and in whether the following data access is forwarded or served internally. A wrong swap decision shows as a reversed word or reversed byte enables on the very next configuration-data request or response. Lost power-management bytes show only when that register is read back. A stuck transaction state shows as a missing or doubled response strobe, or as a request that changes while it is stalled.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    SP_MEM = 2'd0,
    SP_IO  = 2'd1,
    SP_CFG = 2'd2,
    SP_ROM = 2'd3
  } hb_space_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_FWD   = 2'd1,
    K_CADDR = 2'd2,
    K_CDATA = 2'd3
  } hb_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } hb_state_e;

  // decode windows (inclusive bounds)
  localparam logic [31:0] MEMA_LO  = 32'h8000_0000;
  localparam logic [31:0] MEMA_HI  = 32'hFCFF_FFFF;
  localparam logic [31:0] MEMB_LO  = 32'hFD00_0000;
  localparam logic [31:0] MEMB_HI  = 32'hFDFF_FFFF;
  localparam logic [31:0] IOA_LO   = 32'hFE00_0000;
  localparam logic [31:0] IOA_HI   = 32'hFE00_FFFF;
  localparam logic [31:0] IOB_LO   = 32'hFE80_0000;
  localparam logic [31:0] IOB_HI   = 32'hFEBF_FFFF;
  localparam logic [31:0] IOB_BASE = 32'h0080_0000;
  localparam logic [31:0] CADR_LO  = 32'hFEC0_0000;
  localparam logic [31:0] CADR_HI  = 32'hFEDF_FFFF;
  localparam logic [31:0] CDAT_LO  = 32'hFEE0_0000;
  localparam logic [31:0] CDAT_HI  = 32'hFEEF_FFFF;

  localparam logic [23:0] SELF_TAG  = 24'h80_0000;
  localparam logic [5:0]  REG_CMDST = 6'h01;
  localparam logic [5:0]  REG_PWR   = 6'h1C;
  localparam logic [15:0] CMD_RST   = 16'h0006;
  localparam logic [15:0] STAT_RST  = 16'h0080;

  function automatic logic [31:0] hb_swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [3:0] hb_rev4(input logic [3:0] b);
    return {b[0], b[1], b[2], b[3]};
  endfunction

endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
#(
  parameter int ROM_LOG2 = 20
) (
  input  logic [31:0] addr,
  output hb_kind_e    kind,
  output hb_space_e   space,
  output logic [31:0] xaddr
);
  localparam logic [31:0] ROM_MASK = (32'h1 << ROM_LOG2) - 32'h1;

  always_comb begin
    kind  = K_NONE;
    space = SP_MEM;
    xaddr = addr;
    if (&addr[31:ROM_LOG2]) begin
      kind  = K_FWD;
      space = SP_ROM;
      xaddr = addr & ROM_MASK;
    end else if (addr >= MEMA_LO && addr <= MEMA_HI) begin
      kind  = K_FWD;
      space = SP_MEM;
      xaddr = addr;
    end else if (addr >= MEMB_LO && addr <= MEMB_HI) begin
      kind  = K_FWD;
      space = SP_MEM;
      xaddr = addr - MEMB_LO;
    end else if (addr >= IOA_LO && addr <= IOA_HI) begin
      kind  = K_FWD;
      space = SP_IO;
      xaddr = addr - IOA_LO;
    end else if (addr >= IOB_LO && addr <= IOB_HI) begin
      kind  = K_FWD;
      space = SP_IO;
      xaddr = addr - IOB_LO + IOB_BASE;
    end else if (addr >= CADR_LO && addr <= CADR_HI) begin
      kind  = K_CADDR;
    end else if (addr >= CDAT_LO && addr <= CDAT_HI) begin
      kind  = K_CDATA;
    end
  end
endmodule

// File: rtl/hb_cfg_regs.sv
module hb_cfg_regs
  import hb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        caddr_we,
  input  logic        cdata_we,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [31:0] caddr_q,
  output logic        self_hit,
  output logic [31:0] hdr_rdata
);
  logic [31:0] caddr_d;
  logic [15:0] pwr1_q, pwr1_d;
  logic [7:0]  pwr2_q, pwr2_d;
  logic [31:0] wd_sw;
  logic [3:0]  be_sw;
  logic        pwr_we;

  assign wd_sw    = hb_swap32(wdata);
  assign be_sw    = hb_rev4(be);
  assign self_hit = (caddr_q[31:8] == SELF_TAG);
  assign pwr_we   = cdata_we && self_hit && (caddr_q[7:2] == REG_PWR);

  always_comb begin
    caddr_d = caddr_q;
    if (caddr_we) begin
      for (int i = 0; i < 4; i++) begin
        if (be_sw[i]) caddr_d[8*i +: 8] = wd_sw[8*i +: 8];
      end
    end
    pwr1_d = pwr1_q;
    pwr2_d = pwr2_q;
    if (pwr_we) begin
      if (be[0]) pwr1_d[7:0]  = wdata[7:0];
      if (be[1]) pwr1_d[15:8] = wdata[15:8];
      if (be[2]) pwr2_d       = wdata[23:16];
    end
  end

  always_comb begin
    case (caddr_q[7:2])
      REG_CMDST: hdr_rdata = {STAT_RST, CMD_RST};
      REG_PWR:   hdr_rdata = {8'h00, pwr2_q, pwr1_q};
      default:   hdr_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q <= 32'hFFFF_FFFF;
      pwr1_q  <= 16'h0;
      pwr2_q  <= 8'h0;
    end else begin
      caddr_q <= caddr_d;
      pwr1_q  <= pwr1_d;
      pwr2_q  <= pwr2_d;
    end
  end
endmodule

// File: rtl/hb_bridge.sv
module hb_bridge
  import hb_pkg::*;
#(
  parameter int ROM_LOG2 = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req_valid,
  output logic        cpu_req_ready,
  input  logic        cpu_req_we,
  input  logic [31:0] cpu_req_addr,
  input  logic [31:0] cpu_req_wdata,
  input  logic [3:0]  cpu_req_be,
  output logic        cpu_rsp_valid,
  output logic [31:0] cpu_rsp_rdata,
  output logic        pci_req_valid,
  input  logic        pci_req_ready,
  output logic [1:0]  pci_req_space,
  output logic        pci_req_we,
  output logic [31:0] pci_req_addr,
  output logic [31:0] pci_req_wdata,
  output logic [3:0]  pci_req_be,
  input  logic        pci_rsp_valid,
  input  logic [31:0] pci_rsp_rdata,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [5:0]  cfg_reg
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  hb_kind_e    dec_kind;
  hb_space_e   dec_space;
  logic [31:0] dec_xaddr;
  logic [31:0] caddr_q, hdr_rdata;
  logic        self_hit, accept;

  hb_decode #(.ROM_LOG2(ROM_LOG2)) u_dec (
    .addr (cpu_req_addr),
    .kind (dec_kind),
    .space(dec_space),
    .xaddr(dec_xaddr)
  );

  hb_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (srst_n),
    .caddr_we (accept && cpu_req_we && dec_kind == K_CADDR),
    .cdata_we (accept && cpu_req_we && dec_kind == K_CDATA),
    .wdata    (cpu_req_wdata),
    .be       (cpu_req_be),
    .caddr_q  (caddr_q),
    .self_hit (self_hit),
    .hdr_rdata(hdr_rdata)
  );

  hb_state_e   state_q, state_d;
  logic        rsp_v_q, rsp_v_d;
  logic [31:0] rsp_data_q, rsp_data_d;
  logic        req_ld, cfg_fwd;
  hb_space_e   space_q, space_d;
  logic        we_q, swap_q;
  logic [31:0] addr_q, addr_d, wdata_q, wdata_d;
  logic [3:0]  be_q, be_d;

  assign cpu_req_ready = srst_n && (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign cfg_fwd       = (dec_kind == K_CDATA);

  assign space_d = cfg_fwd ? SP_CFG : dec_space;
  assign addr_d  = cfg_fwd ? {caddr_q[31:2], 2'b00} : dec_xaddr;
  assign wdata_d = cfg_fwd ? hb_swap32(cpu_req_wdata) : cpu_req_wdata;
  assign be_d    = cfg_fwd ? hb_rev4(cpu_req_be) : cpu_req_be;

  always_comb begin
    state_d    = state_q;
    rsp_v_d    = 1'b0;
    rsp_data_d = rsp_data_q;
    req_ld     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (dec_kind)
            K_NONE: begin
              rsp_v_d    = 1'b1;
              rsp_data_d = 32'hFFFF_FFFF;
            end
            K_CADDR: begin
              rsp_v_d    = 1'b1;
              rsp_data_d = hb_swap32(caddr_q);
            end
            K_CDATA: begin
              if (self_hit) begin
                rsp_v_d    = 1'b1;
                rsp_data_d = hdr_rdata;
              end else begin
                state_d = ST_ISSUE;
                req_ld  = 1'b1;
              end
            end
            default: begin
              state_d = ST_ISSUE;
              req_ld  = 1'b1;
            end
          endcase
        end
      end
      ST_ISSUE: begin
        if (pci_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (pci_rsp_valid) begin
          rsp_v_d    = 1'b1;
          rsp_data_d = swap_q ? hb_swap32(pci_rsp_rdata) : pci_rsp_rdata;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q    <= ST_IDLE;
      rsp_v_q    <= 1'b0;
      rsp_data_q <= 32'h0;
      space_q    <= SP_MEM;
      we_q       <= 1'b0;
      swap_q     <= 1'b0;
      addr_q     <= 32'h0;
      wdata_q    <= 32'h0;
      be_q       <= 4'h0;
    end else begin
      state_q    <= state_d;
      rsp_v_q    <= rsp_v_d;
      rsp_data_q <= rsp_data_d;
      if (req_ld) begin
        space_q <= space_d;
        we_q    <= cpu_req_we;
        swap_q  <= cfg_fwd;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        be_q    <= be_d;
      end
    end
  end

  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_rdata = rsp_data_q;
  assign pci_req_valid = (state_q == ST_ISSUE);
  assign pci_req_space = space_q;
  assign pci_req_we    = we_q;
  assign pci_req_addr  = addr_q;
  assign pci_req_wdata = wdata_q;
  assign pci_req_be    = be_q;
  assign cfg_bus       = caddr_q[23:16];
  assign cfg_dev       = caddr_q[15:11];
  assign cfg_func      = caddr_q[10:8];
  assign cfg_reg       = caddr_q[7:2];
endmodule

// File: rtl/hb_bridge_chk.sv
module hb_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req_valid,
  input logic        cpu_req_ready,
  input logic        cpu_req_we,
  input logic [31:0] cpu_req_addr,
  input logic        cpu_rsp_valid,
  input logic [31:0] cpu_rsp_rdata,
  input logic        pci_req_valid,
  input logic        pci_req_ready,
  input logic [1:0]  pci_req_space,
  input logic [31:0] pci_req_addr,
  input logic [31:0] pci_req_wdata,
  input logic [3:0]  pci_req_be
);
  logic acc;
  assign acc = cpu_req_valid && cpu_req_ready;

  // R1
  mem_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cpu_req_addr >= 32'h8000_0000 && cpu_req_addr <= 32'hFCFF_FFFF)
    |=> (pci_req_valid && pci_req_space == 2'd0 && pci_req_addr == $past(cpu_req_addr)));

  // R10
  unmapped_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cpu_req_we && cpu_req_addr < 32'h8000_0000)
    |=> (cpu_rsp_valid && cpu_rsp_rdata == 32'hFFFF_FFFF && !pci_req_valid));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && !pci_req_ready)
    |=> (pci_req_valid && $stable(pci_req_addr) && $stable(pci_req_wdata)
         && $stable(pci_req_be) && $stable(pci_req_space)));

  // R13
  single_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req_valid |-> !cpu_req_ready);

  // R13
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rsp_valid && pci_req_valid));
endmodule

bind hb_bridge hb_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready),
  .cpu_req_we   (cpu_req_we),
  .cpu_req_addr (cpu_req_addr),
  .cpu_rsp_valid(cpu_rsp_valid),
  .cpu_rsp_rdata(cpu_rsp_rdata),
  .pci_req_valid(pci_req_valid),
  .pci_req_ready(pci_req_ready),
  .pci_req_space(pci_req_space),
  .pci_req_addr (pci_req_addr),
  .pci_req_wdata(pci_req_wdata),
  .pci_req_be   (pci_req_be)
);

// File: tb/hb_bridge_tb.sv
module hb_bridge_tb;
  localparam int ROM_LOG2 = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic [3:0]  cpu_req_be = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        pci_req_valid, pci_req_we;
  logic        pci_req_ready = 1'b0, pci_rsp_valid = 1'b0;
  logic [31:0] pci_rsp_rdata = '0;
  logic [1:0]  pci_req_space;
  logic [31:0] pci_req_addr, pci_req_wdata;
  logic [3:0]  pci_req_be;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;

  always #10 clk = ~clk;

  hb_bridge #(.ROM_LOG2(ROM_LOG2)) u_dut (.*);

  int checks = 0, failures = 0;

  // reference model state
  logic [31:0] m_caddr;
  logic [15:0] m_pw1;
  logic [7:0]  m_pw2;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rev_bytes(input logic [31:0] w);
    return {<<8{w}};
  endfunction

  function automatic logic [3:0] rev_be(input logic [3:0] b);
    return {<<{b}};
  endfunction

  task automatic txn(input bit we, input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic [31:0] prd, input int stall,
                     input string tag);
    bit fwd = 0;
    logic [1:0]  e_sp = 2'd0;
    logic [31:0] e_ad = 32'h0, e_wd = d, e_rd = 32'hFFFF_FFFF;
    logic [3:0]  e_be = be;
    logic [31:0] rom_base = 32'hFFFF_FFFF - ((32'h1 << ROM_LOG2) - 1);
    if (a >= rom_base) begin
      fwd = 1; e_sp = 2'd3; e_ad = a - rom_base; e_rd = prd;
    end else if (a >= 32'h8000_0000 && a < 32'hFD00_0000) begin
      fwd = 1; e_sp = 2'd0; e_ad = a; e_rd = prd;
    end else if (a >= 32'hFD00_0000 && a < 32'hFE00_0000) begin
      fwd = 1; e_sp = 2'd0; e_ad = a - 32'hFD00_0000; e_rd = prd;
    end else if (a >= 32'hFE00_0000 && a < 32'hFE01_0000) begin
      fwd = 1; e_sp = 2'd1; e_ad = a - 32'hFE00_0000; e_rd = prd;
    end else if (a >= 32'hFE80_0000 && a < 32'hFEC0_0000) begin
      fwd = 1; e_sp = 2'd1; e_ad = a - 32'hFE00_0000; e_rd = prd;
    end else if (a >= 32'hFEC0_0000 && a < 32'hFEE0_0000) begin
      e_rd = rev_bytes(m_caddr);
      if (we) for (int i = 0; i < 4; i++)
        if (be[i]) m_caddr[31-8*i -: 8] = d[8*i +: 8];
    end else if (a >= 32'hFEE0_0000 && a < 32'hFEF0_0000) begin
      if (m_caddr[31:8] == 24'h800000) begin
        if (m_caddr[7:2] == 6'd1) e_rd = 32'h0080_0006;
        else if (m_caddr[7:0] == 8'h70) e_rd = {8'h00, m_pw2, m_pw1};
        else e_rd = 32'h0;
        if (we && m_caddr[7:0] == 8'h70) begin
          if (be[0]) m_pw1[7:0] = d[7:0];
          if (be[1]) m_pw1[15:8] = d[15:8];
          if (be[2]) m_pw2 = d[23:16];
        end
      end else begin
        fwd = 1; e_sp = 2'd2; e_ad = m_caddr & 32'hFFFF_FFFC;
        e_wd = rev_bytes(d); e_be = rev_be(be); e_rd = rev_bytes(prd);
      end
    end
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, {tag, " R13 ready idle"}, 32'(cpu_req_ready), 32'h1);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d; cpu_req_be = be;
    @(negedge clk);
    cpu_req_valid = 0;
    if (fwd) begin
      chk(pci_req_valid && !cpu_req_ready, {tag, " R13 req issued/busy"}, 32'(pci_req_valid), 32'h1);
      chk(pci_req_space == e_sp, {tag, " space"}, 32'(pci_req_space), 32'(e_sp));
      chk(pci_req_addr == e_ad, {tag, " addr"}, pci_req_addr, e_ad);
      chk(pci_req_we == we, {tag, " R12 we"}, 32'(pci_req_we), 32'(we));
      if (we) begin
        chk(pci_req_wdata == e_wd, {tag, " wdata"}, pci_req_wdata, e_wd);
        chk(pci_req_be == e_be, {tag, " be"}, 32'(pci_req_be), 32'(e_be));
      end
      if (e_sp == 2'd2) begin
        chk({cfg_bus, cfg_dev, cfg_func, cfg_reg} == {m_caddr[23:2]}, {tag, " R7 cfg fields"},
            32'({cfg_bus, cfg_dev, cfg_func, cfg_reg}), 32'(m_caddr[23:2]));
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(pci_req_valid && pci_req_addr == e_ad && pci_req_space == e_sp,
            {tag, " R11 held while stalled"}, pci_req_addr, e_ad);
        chk(!cpu_rsp_valid, {tag, " R13 no early rsp"}, 32'(cpu_rsp_valid), 32'h0);
      end
      pci_req_ready = 1;
      @(negedge clk);
      pci_req_ready = 0;
      chk(!pci_req_valid, {tag, " R11 req dropped after ready"}, 32'(pci_req_valid), 32'h0);
      pci_rsp_valid = 1; pci_rsp_rdata = prd;
      @(negedge clk);
      pci_rsp_valid = 0;
    end else begin
      chk(!pci_req_valid, {tag, " R10 no pci req"}, 32'(pci_req_valid), 32'h0);
    end
    chk(cpu_rsp_valid == 1'b1, {tag, " R13 rsp strobe"}, 32'(cpu_rsp_valid), 32'h1);
    if (!we) chk(cpu_rsp_rdata == e_rd, {tag, " rdata"}, cpu_rsp_rdata, e_rd);
    @(negedge clk);
    chk(!cpu_rsp_valid, {tag, " R13 single pulse"}, 32'(cpu_rsp_valid), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_caddr = 32'hFFFF_FFFF; m_pw1 = 16'h0; m_pw2 = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk(!cpu_rsp_valid && !pci_req_valid, "R6 idle after reset", 32'({cpu_rsp_valid, pci_req_valid}), 32'h0);
    chk(cfg_bus == 8'hFF && cfg_reg == 6'h3F, "R6 cfg fields reset", 32'({cfg_bus, cfg_reg}), 32'h3FFF);
    txn(0, 32'hFEC0_0000, 0, 4'hF, 0, 0, "R6 caddr reset read");
    // R1 / R12 memory window A, stalled
    txn(1, 32'h8123_4568, 32'hCAFE_F00D, 4'b0110, 0, 3, "R1 R12 memA write");
    txn(0, 32'hFCFF_FFFC, 0, 4'hF, 32'h1234_5678, 1, "R1 R12 memA read top");
    // R2 memory window B
    txn(0, 32'hFD00_0010, 0, 4'hF, 32'hA5A5_0001, 0, "R2 memB read");
    txn(1, 32'hFDFF_FFF0, 32'h0BAD_BEEF, 4'b1000, 0, 2, "R2 memB write");
    // R3 I/O windows
    txn(0, 32'hFE00_FFFC, 0, 4'hF, 32'h0000_00AB, 0, "R3 ioA read");
    txn(1, 32'hFE80_0004, 32'h5566_7788, 4'b0011, 0, 0, "R3 ioB write");
    txn(0, 32'hFEBF_FFFC, 0, 4'hF, 32'h1111_2222, 0, "R3 ioB read top");
    // R4 ROM
    txn(0, 32'hFFF0_0000, 0, 4'hF, 32'h7F45_4C46, 0, "R4 rom first");
    txn(0, 32'hFFFF_FFFC, 0, 4'hF, 32'h4800_0100, 0, "R4 rom last");
    // R10 unmapped
    txn(0, 32'h0000_1000, 0, 4'hF, 0, 0, "R10 low read");
    txn(0, 32'hFE01_0000, 0, 4'hF, 0, 0, "R10 gap read");
    txn(1, 32'hFEF0_0000, 32'h0, 4'hF, 0, 0, "R10 gap write");
    txn(0, 32'hFEC0_0000, 0, 4'hF, 0, 0, "R10 caddr unchanged");
    // R5 config address swap and partial write
    txn(1, 32'hFEC0_0000, 32'h140A_0180, 4'hF, 0, 0, "R5 caddr write");
    txn(0, 32'hFEC0_0004, 0, 4'hF, 0, 0, "R5 caddr read");
    txn(1, 32'hFEC0_0000, 32'hDEAD_BE14, 4'b0001, 0, 0, "R5 caddr partial");
    txn(0, 32'hFEC0_0000, 0, 4'hF, 0, 0, "R5 caddr partial read");
    // R7 config data to another function
    txn(1, 32'hFEE0_0000, 32'h1122_3344, 4'b0011, 0, 1, "R7 cdata write swap");
    txn(0, 32'hFEE0_0000, 0, 4'hF, 32'hA1B2_C3D4, 0, "R7 cdata read swap");
    // R8 bridge header unswapped
    txn(1, 32'hFEC0_0000, 32'h0400_0080, 4'hF, 0, 0, "R8 select cmd");
    txn(0, 32'hFEE0_0000, 0, 4'hF, 0, 0, "R8 cmd status read");
    // R9 power registers
    txn(1, 32'hFEC0_0000, 32'h7000_0080, 4'hF, 0, 0, "R9 select pwr");
    txn(0, 32'hFEE0_0000, 0, 4'hF, 0, 0, "R9 pwr reset");
    txn(1, 32'hFEE0_0000, 32'hAABB_CCDD, 4'b0101, 0, 0, "R9 pwr write lanes 0 2");
    txn(0, 32'hFEE0_0000, 0, 4'hF, 0, 0, "R9 pwr read a");
    txn(1, 32'hFEE0_0000, 32'h1122_3344, 4'b1010, 0, 0, "R9 pwr write lanes 1 3");
    txn(0, 32'hFEE0_0000, 0, 4'hF, 0, 0, "R9 pwr read b");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule